// File: doc/BRIEF.md
# Constant Divider by Series Expansion

This block divides an unsigned integer by a divisor fixed at elaboration time, using only shifts, adds and constant products. The odd part of the divisor, `DIV`, is paired with a multiplier `MUL` and a shift `NSH` chosen so that `DIV * MUL = 2^NSH - 1`. The reciprocal is then `MUL / (2^NSH - 1)`, which equals `MUL / 2^NSH` times a chain of factors `(1 + 2^-NSH)(1 + 2^-2NSH)(1 + 2^-4NSH)...`. Each factor is one add of a running value to a right-shifted copy of itself, so the chain needs only a logarithmic number of adders.

An even divisor `DIV * 2^SHR` is handled by dropping the low `SHR` bits of the input before the chain and putting them back into the remainder. Every step of the chain truncates and the series is cut short, so the estimate is never high and at most one below the true quotient. A final stage forms the remainder, and if it is not below the divisor it adds one to the quotient and subtracts the divisor from the remainder.

The unit is fully pipelined. It accepts one operand per clock cycle, with a valid flag, and returns the quotient and remainder a fixed number of cycles later.

Top module: `const_div_series`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is low after that edge, and operands offered during reset never produce a result.
- R2: Each operand accepted with `in_valid` high gives exactly one result with `out_valid` high, in order, `STAGES + 3` rising edges later (the capture edge is counted). `STAGES` is the smallest s >= 1 with `NSH * 2^s >= (W - SHR) + GUARD`, which is 2 for the default parameters, so the latency is 5. The unit accepts a new operand every cycle, and an idle input cycle produces no result.
- R3: `quo` equals floor(`in_z` / (`DIV * 2^SHR`)) for every input value, including 0 and all ones.
- R4: `rem` equals `in_z - quo * DIV * 2^SHR` and is always less than `DIV * 2^SHR`.
- R5: The shift-add estimate is never above the true quotient and at most one below it. The correction stage turns it into the exact result, including for inputs that are exact multiples of the divisor, where the truncated estimate falls one short.
- R6: For an even divisor (`SHR > 0`), bits `[SHR-1:0]` of `rem` equal bits `[SHR-1:0]` of the operand they belong to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears the valid flags |
| in_valid | input | 1 | Operand on `in_z` is accepted this cycle |
| in_z | input | W | Unsigned dividend |
| out_valid | output | 1 | `quo` and `rem` hold a result |
| quo | output | W | Quotient, truncated toward zero |
| rem | output | W | Remainder, below the divisor |

## Verification
Two instances are exercised side by side: the default divide-by-7 on 16 bits, and a divide-by-6 on 8 bits built from the divisor 3 with a one-bit trailing shift. The 8-bit instance sweeps its whole input space. Its low remainder bit shows whether the trailing-shift path keeps the dropped bit. The 16-bit instance gets directed values (zero, all ones, values next to multiples of 7) and random values. About a fifth of the random values are exact multiples, which are the cases where the uncorrected estimate is one short, so they show whether the correction stage works. Random idle cycles between operands check that gaps produce no result and that the fixed latency holds.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Smallest s >= 1 with nsh * 2^s >= bits: the number of factor stages
  // needed so the neglected series tail stays below the guard precision.
  function automatic int stage_count(input int nsh, input int bits);
    for (int s = 1; s < 31; s++) begin
      if ((nsh << s) >= bits) return s;
    end
    return 31;
  endfunction

  // Number of bits needed to hold the unsigned value v.
  function automatic int bit_width(input int v);
    int b;
    b = 1;
    while ((64'(1) << b) <= 64'(v)) b++;
    return b;
  endfunction

endpackage

// File: rtl/cdiv_premul.sv
// First pipeline stage: drop the low SHR bits and multiply the odd part
// of the dividend by the constant MUL.
module cdiv_premul #(
  parameter int W   = 16,
  parameter int SHR = 0,
  parameter int MUL = 9,
  parameter int ZW  = W - SHR,
  parameter int PW  = ZW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_z,
  output logic          out_valid,
  output logic [W-1:0]  out_z,
  output logic [PW-1:0] out_p
);

  logic [ZW-1:0] z_odd;
  assign z_odd = in_z[W-1:SHR];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
    out_z <= in_z;
    out_p <= PW'(z_odd) * PW'(MUL);
  end

endmodule

// File: rtl/cdiv_factor.sv
// One series factor: v * (1 + 2^-SH), done as a single shift-add on a
// fixed-point value that carries guard bits below the integer point.
module cdiv_factor #(
  parameter int W  = 16,
  parameter int VW = 24,
  parameter int SH = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_z,
  input  logic [VW-1:0] in_v,
  output logic          out_valid,
  output logic [W-1:0]  out_z,
  output logic [VW-1:0] out_v
);

  logic [VW-1:0] shifted;
  assign shifted = in_v >> SH;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
    out_z <= in_z;
    out_v <= in_v + shifted;
  end

endmodule

// File: rtl/cdiv_fix.sv
// Last two stages: take the integer part of the series estimate, then
// form the remainder and correct a quotient that came out one short.
module cdiv_fix #(
  parameter int W     = 16,
  parameter int SHR   = 0,
  parameter int DIV   = 7,
  parameter int ZW    = W - SHR,
  parameter int DW    = 3,
  parameter int VW    = 24,
  parameter int QSH   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_z,
  input  logic [VW-1:0] in_v,
  output logic          out_valid,
  output logic [W-1:0]  quo,
  output logic [W-1:0]  rem
);

  localparam int RW = ZW + DW;
  localparam logic [W-1:0]  LOW_MASK = (W'(1) << SHR) - W'(1);
  localparam logic [RW-1:0] DIV_R    = RW'(DIV);
  localparam logic [RW:0]   DIV_R2   = (RW + 1)'(DIV) << 1;
  localparam logic [W:0]    DIV_FULL = (W + 1)'(DIV) << SHR;
  localparam int CW = 2 * W + 2;

  // Stage A: integer part of the estimate.
  logic          vld_a;
  logic [W-1:0]  z_a;
  logic [ZW-1:0] q_a;

  always_ff @(posedge clk) begin
    if (rst) vld_a <= 1'b0;
    else     vld_a <= in_valid;
    z_a <= in_z;
    q_a <= ZW'(in_v >> QSH);
  end

  // Remainder of the estimate and one-step correction.
  logic [ZW-1:0] zo_a;
  logic [RW-1:0] prod, rem_raw, rem_odd;
  logic          need_fix;
  logic [ZW-1:0] q_fix;

  always_comb begin
    zo_a     = z_a[W-1:SHR];
    prod     = RW'(q_a) * DIV_R;
    rem_raw  = RW'(zo_a) - prod;
    need_fix = (rem_raw >= DIV_R);
    rem_odd  = need_fix ? (rem_raw - DIV_R) : rem_raw;
    q_fix    = q_a + ZW'(need_fix);
  end

  // Stage B: registered result.
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= vld_a;
    quo <= W'(q_fix);
    rem <= (W'(rem_odd) << SHR) | (z_a & LOW_MASK);
  end

  // Estimate never overshoots the dividend (R5).
  p_est_not_high_r5: assert property (@(posedge clk) disable iff (rst)
    vld_a |-> (prod <= RW'(zo_a)));

  // Estimate is at most one quotient step short (R5).
  p_est_one_short_r5: assert property (@(posedge clk) disable iff (rst)
    vld_a |-> ((RW + 1)'(rem_raw) < DIV_R2));

  // Remainder stays below the full divisor (R4).
  p_rem_below_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({1'b0, rem} < DIV_FULL));

  // Quotient and remainder rebuild the dividend (R3).
  p_rebuild_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (CW'(quo) * CW'(DIV_FULL) + CW'(rem) == CW'($past(z_a))));

  // Bits dropped by the trailing shift return in the remainder (R6).
  p_low_bits_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((rem & LOW_MASK) == ($past(z_a) & LOW_MASK)));

endmodule

// File: rtl/const_div_series.sv
// Pipelined divide by the constant DIV * 2^SHR using DIV * MUL = 2^NSH - 1.
module const_div_series
  import cdiv_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV   = 7,
  parameter int MUL   = 9,
  parameter int NSH   = 6,
  parameter int SHR   = 0,
  parameter int GUARD = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_z,
  output logic         out_valid,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  localparam int ZW     = W - SHR;
  localparam int MW     = bit_width(MUL);
  localparam int DW     = bit_width(DIV);
  localparam int PW     = ZW + MW;
  localparam int VW     = PW + 1 + GUARD;
  localparam int STAGES = stage_count(NSH, ZW + GUARD);

  logic          vld_p;
  logic [W-1:0]  z_p;
  logic [PW-1:0] p_p;

  cdiv_premul #(.W(W), .SHR(SHR), .MUL(MUL), .ZW(ZW), .PW(PW)) u_premul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(in_z),
    .out_valid(vld_p), .out_z(z_p), .out_p(p_p)
  );

  // Factor chain: element 0 is the product with guard bits appended.
  logic          vld_ch [0:STAGES];
  logic [W-1:0]  z_ch   [0:STAGES];
  logic [VW-1:0] v_ch   [0:STAGES];

  assign vld_ch[0] = vld_p;
  assign z_ch[0]   = z_p;
  assign v_ch[0]   = {1'b0, p_p, {GUARD{1'b0}}};

  for (genvar k = 0; k < STAGES; k++) begin : g_factor
    cdiv_factor #(.W(W), .VW(VW), .SH(NSH << k)) u_factor (
      .clk(clk), .rst(rst),
      .in_valid(vld_ch[k]), .in_z(z_ch[k]), .in_v(v_ch[k]),
      .out_valid(vld_ch[k+1]), .out_z(z_ch[k+1]), .out_v(v_ch[k+1])
    );
  end

  cdiv_fix #(
    .W(W), .SHR(SHR), .DIV(DIV), .ZW(ZW), .DW(DW), .VW(VW), .QSH(NSH + GUARD)
  ) u_fix (
    .clk(clk), .rst(rst),
    .in_valid(vld_ch[STAGES]), .in_z(z_ch[STAGES]), .in_v(v_ch[STAGES]),
    .out_valid(out_valid), .quo(quo), .rem(rem)
  );

  // Reset empties the pipeline (R1).
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: tb/tb_const_div_series.sv
module tb_const_div_series;

  typedef struct {
    int          due;
    logic [15:0] q;
    logic [15:0] r;
    logic [15:0] z;
    bit          mult;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] za = '0;
  logic [7:0]  zb = '0;
  logic        va, vb;
  logic [15:0] qa, ra;
  logic [7:0]  qb, rb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  exp_t qa_exp[$];
  exp_t qb_exp[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Default instance: divide by 7 on 16 bits.
  const_div_series dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(za),
    .out_valid(va), .quo(qa), .rem(ra)
  );

  // Even divisor 6 = 3 * 2 on 8 bits (3 * 5 = 2^4 - 1).
  const_div_series #(.W(8), .DIV(3), .MUL(5), .NSH(4), .SHR(1), .GUARD(4)) dut_b (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(zb),
    .out_valid(vb), .quo(qb), .rem(rb)
  );

  // Latency rule from R2, computed independently of the design.
  function automatic int exp_latency(input int nsh, input int zw, input int guard);
    int s;
    s = 1;
    while ((nsh << s) < zw + guard) s++;
    return s + 3;
  endfunction

  localparam int LAT_A = exp_latency(6, 16, 4);
  localparam int LAT_B = exp_latency(4, 7, 4);

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, expv, cyc);
    end
  endtask

  task automatic mon(input string tag, input logic v, input logic [15:0] q,
                     input logic [15:0] r, input bit chk_low, ref exp_t qq[$]);
    exp_t e;
    if (v) begin
      if (qq.size() == 0) begin
        check(1'b0, {"R2 ", tag, " result without operand"}, 1, 0);
      end else begin
        e = qq.pop_front();
        check(e.due == cyc, {"R2 ", tag, " latency"}, cyc, e.due);
        if (e.mult)
          check(q == e.q, {"R5 ", tag, " quotient of exact multiple"}, q, e.q);
        else
          check(q == e.q, {"R3 ", tag, " quotient"}, q, e.q);
        check(r == e.r, {"R4 ", tag, " remainder"}, r, e.r);
        if (chk_low)
          check(r[0] == e.z[0], {"R6 ", tag, " low remainder bit"}, r[0], e.z[0]);
      end
    end else if (qq.size() > 0 && qq[0].due <= cyc) begin
      e = qq.pop_front();
      check(1'b0, {"R2 ", tag, " missing result"}, 0, 1);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      mon("div7", va, qa, ra, 1'b0, qa_exp);
      mon("div6", vb, {8'd0, qb}, {8'd0, rb}, 1'b1, qb_exp);
    end
  end

  task automatic send(input logic [15:0] a, input logic [7:0] b);
    exp_t e;
    in_valid = 1'b1;
    za = a;
    zb = b;
    e.due = cyc + LAT_A; e.z = a; e.q = a / 16'd7; e.r = a % 16'd7; e.mult = (a % 7 == 0);
    qa_exp.push_back(e);
    e.due = cyc + LAT_B; e.z = {8'd0, b}; e.q = {8'd0, b / 8'd6}; e.r = {8'd0, b % 8'd6};
    e.mult = (b % 6 == 0);
    qb_exp.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  int corners[13] = '{0, 1, 6, 7, 8, 13, 14, 48, 49, 65535, 65534, 65527, 65528};

  initial begin
    logic [15:0] a;
    void'($urandom(32'h5eed_0c7d));
    // Operands offered during reset must be dropped (R1).
    repeat (3) begin
      @(negedge clk);
      in_valid = 1'b1;
      za = 16'(($urandom % 65536));
      zb = 8'($urandom % 256);
    end
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(va == 1'b0, "R1 div7 out_valid after reset", va, 0);
    check(vb == 1'b0, "R1 div6 out_valid after reset", vb, 0);
    repeat (8) @(negedge clk);
    check(qa_exp.size() == 0 && va == 1'b0, "R1 no result from reset operands", va, 0);

    for (int i = 0; i < 3000; i++) begin
      if (i < 13)            a = 16'(corners[i]);
      else if (i % 5 == 0)   a = 16'(($urandom % 9363) * 7);
      else                   a = 16'($urandom % 65536);
      send(a, 8'(i));
      // Idle cycles between operands (R2: no result for a gap).
      if (i > 300 && ($urandom % 4 == 0)) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    check(qa_exp.size() == 0, "R2 div7 all results delivered", qa_exp.size(), 0);
    check(qb_exp.size() == 0, "R2 div6 all results delivered", qb_exp.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule